// File: doc/BRIEF.md
# Edge-Triggered Input Capture FIFO

This block watches a bank of general-purpose input pins and, when a pin shows the edge that its configuration selects, records the current precision time together with the index of that pin. Each record goes into a 64-deep first-in first-out store. The pins may be asynchronous to the block clock, so each one passes through a two-stage synchroniser before its edge is detected.

Software reads each record as six 16-bit words through a single read port. The least significant word comes first. When the advance control is set, each access strobe moves the port to the next word, and the strobe after the last word retires the record. A fill-level output gives the number of stored records. A sticky overrun flag shows that an edge was lost because the store was full. A pointer-reset command empties the store and clears the flag.

Top module: `edge_stamp_fifo`

## Requirements
- R1: Each pin has a 2-bit mode in `edgeCfg[2p+1:2p]`. Code 01 captures rising edges, code 10 captures falling edges, and codes 00 and 11 capture nothing.
- R2: A record is 96 bits. Bits [29:0] hold the nanoseconds and bits [77:30] hold the seconds, both taken from the time bus in the cycle the record is written. Bits [82:78] hold the pin index and bits [95:83] are zero.
- R3: `fillLevel` equals the number of stored records, from 0 (empty) to 64 (full).
- R4: Read word k of the oldest record is record bits [16k+15:16k], for k from 0 to 5, and word 0 is presented first. `readData` is 0 while the store is empty.
- R5: A `readStrobe` pulse with `readNext` high advances to the next word, and the strobe on word 5 removes the record and returns to word 0. A strobe with `readNext` low changes nothing.
- R6: `ptrReset` empties the store, discards edges that are waiting to be stored, returns the read port to word 0 and clears `overrun`.
- R7: `overrun` rises when a detected edge cannot be stored because the store is full, and it stays high until `ptrReset`.
- R8: When the store is full, new edges are dropped and the stored records are kept unchanged.
- R9: Edges detected in the same cycle on several pins are stored in ascending pin order, one record per cycle.
- R10: An input change made between two clock edges increases `fillLevel` on the fourth rising clock edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 20 | Monitored inputs, possibly asynchronous |
| edgeCfg | input | 40 | Two-bit edge mode for each pin |
| timeSec | input | 48 | Current time, seconds part |
| timeNs | input | 30 | Current time, nanoseconds part |
| readNext | input | 1 | When high, access strobes advance the read word |
| readStrobe | input | 1 | One-cycle pulse for each read access |
| ptrReset | input | 1 | Empties the store and clears overrun |
| readData | output | 16 | Current word of the oldest record |
| fillLevel | output | 7 | Number of stored records |
| overrun | output | 1 | Sticky flag for a lost edge |

## Verification
A wrong record count shows at once on `fillLevel`. Its effects can also appear later, as a record that is read twice, a record that is skipped, or an `overrun` flag that never rises once 64 records are stored. A wrong word index or read pointer shows on the next access, because `readData` then carries words out of order or from the wrong record. The scoreboard compares every word of every record with a record built from the pin index and the time that the bench drove. An arbitration fault among pins that fire together shows as pin indices out of ascending order in consecutive records.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;       // store one record this cycle
    logic popRec;     // retire the oldest record
    logic clearPtrs;  // return both pointers to zero
    logic empty;      // nothing stored
  } stampCtl_t;
endpackage

// File: rtl/edge_stamp_ctrl.sv
module edge_stamp_ctrl
  import edge_stamp_pkg::*;
#(
  parameter int NUM_PINS  = 20,
  parameter int DEPTH     = 64,
  parameter int WORDS     = 6,
  parameter int PIN_IDX_W = 5,
  parameter int CNT_W     = 7,
  parameter int WSEL_W    = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [2*NUM_PINS-1:0] edgeCfg,
  input  logic                  readNext,
  input  logic                  readStrobe,
  input  logic                  ptrReset,
  output stampCtl_t             ctl,
  output logic [PIN_IDX_W-1:0]  wrPin,
  output logic [WSEL_W-1:0]     wordSel,
  output logic [CNT_W-1:0]      fillLevel,
  output logic                  overrun
);
  logic [NUM_PINS-1:0] syncA, syncB, prevB, pending, hits, selMask;
  logic [CNT_W-1:0]    count;
  logic [WSEL_W-1:0]   wordIdx;
  logic                selValid, full, drop, advance, lastWord, popRec, wrEn;
  logic [PIN_IDX_W-1:0] selIdx;

  // Two-stage synchroniser and a history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_edge
    logic [1:0] mode;
    assign mode    = edgeCfg[2*g +: 2];
    assign hits[g] = ((mode == 2'b01) &&  syncB[g] && !prevB[g]) ||
                     ((mode == 2'b10) && !syncB[g] &&  prevB[g]);
  end

  // Lowest waiting pin wins
  always_comb begin
    selValid = 1'b0;
    selIdx   = '0;
    selMask  = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (pending[i]) begin
        selValid = 1'b1;
        selIdx   = PIN_IDX_W'(i);
      end
    end
    if (selValid) selMask[selIdx] = 1'b1;
  end

  assign full     = (count == CNT_W'(DEPTH));
  assign wrEn     = selValid && !full && !ptrReset;
  assign drop     = selValid && full && !ptrReset;
  assign advance  = readStrobe && readNext && (count != '0) && !ptrReset;
  assign lastWord = (wordIdx == WSEL_W'(WORDS - 1));
  assign popRec   = advance && lastWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= '0;
      count   <= '0;
      wordIdx <= '0;
      overrun <= 1'b0;
    end else if (ptrReset) begin
      pending <= '0;
      count   <= '0;
      wordIdx <= '0;
      overrun <= 1'b0;
    end else begin
      pending <= (pending & ~selMask) | hits;
      count   <= count + CNT_W'(wrEn) - CNT_W'(popRec);
      if (advance) wordIdx <= lastWord ? '0 : wordIdx + 1'b1;
      if (drop) overrun <= 1'b1;
    end
  end

  assign ctl.wrEn      = wrEn;
  assign ctl.popRec    = popRec;
  assign ctl.clearPtrs = ptrReset;
  assign ctl.empty     = (count == '0);
  assign wrPin         = selIdx;
  assign wordSel       = wordIdx;
  assign fillLevel     = count;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= CNT_W'(DEPTH)); // R3
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (full && !popRec && !ptrReset) |=> (fillLevel == CNT_W'(DEPTH))); // R8
  AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    ptrReset |=> (fillLevel == '0 && !overrun && wordSel == '0)); // R6
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !ptrReset) |=> overrun); // R7
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !lastWord) |=> (wordSel == $past(wordSel) + 1'b1)); // R5
  AST_STROBE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!readNext && !ptrReset) |=> $stable(wordSel)); // R5
endmodule

// File: rtl/edge_stamp_dp.sv
module edge_stamp_dp
  import edge_stamp_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int SEC_W     = 48,
  parameter int NS_W      = 30,
  parameter int PIN_IDX_W = 5,
  parameter int WORDS     = 6,
  parameter int WSEL_W    = 3,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stampCtl_t            ctl,
  input  logic [PIN_IDX_W-1:0] wrPin,
  input  logic [WSEL_W-1:0]    wordSel,
  input  logic [SEC_W-1:0]     timeSec,
  input  logic [NS_W-1:0]      timeNs,
  output logic [15:0]          readData
);
  localparam int REC_W = WORDS * 16;
  localparam int PAD_W = REC_W - SEC_W - NS_W - PIN_IDX_W;

  logic [REC_W-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr, rdPtr;

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] p);
    return (p == ADDR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (ctl.clearPtrs) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.wrEn)   wrPtr <= bump(wrPtr);
      if (ctl.popRec) rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrEn) mem[wrPtr] <= {{PAD_W{1'b0}}, wrPin, timeSec, timeNs};
  end

  assign readData = ctl.empty ? 16'h0 : mem[rdPtr][wordSel*16 +: 16];

  AST_NO_WRITE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clearPtrs |-> !ctl.wrEn); // R6
endmodule

// File: rtl/edge_stamp_fifo.sv
module edge_stamp_fifo
  import edge_stamp_pkg::*;
#(
  parameter int NUM_PINS = 20,
  parameter int DEPTH    = 64,
  parameter int SEC_W    = 48,
  parameter int NS_W     = 30
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_PINS-1:0]      pinIn,
  input  logic [2*NUM_PINS-1:0]    edgeCfg,
  input  logic [SEC_W-1:0]         timeSec,
  input  logic [NS_W-1:0]          timeNs,
  input  logic                     readNext,
  input  logic                     readStrobe,
  input  logic                     ptrReset,
  output logic [15:0]              readData,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic                     overrun
);
  localparam int PIN_IDX_W = $clog2(NUM_PINS);
  localparam int WORDS     = (SEC_W + NS_W + PIN_IDX_W + 15) / 16;
  localparam int WSEL_W    = $clog2(WORDS);
  localparam int ADDR_W    = $clog2(DEPTH);
  localparam int CNT_W     = $clog2(DEPTH + 1);

  stampCtl_t            ctl;
  logic [PIN_IDX_W-1:0] wrPin;
  logic [WSEL_W-1:0]    wordSel;

  edge_stamp_ctrl #(
    .NUM_PINS(NUM_PINS), .DEPTH(DEPTH), .WORDS(WORDS),
    .PIN_IDX_W(PIN_IDX_W), .CNT_W(CNT_W), .WSEL_W(WSEL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .edgeCfg(edgeCfg),
    .readNext(readNext), .readStrobe(readStrobe), .ptrReset(ptrReset),
    .ctl(ctl), .wrPin(wrPin), .wordSel(wordSel),
    .fillLevel(fillLevel), .overrun(overrun)
  );

  edge_stamp_dp #(
    .DEPTH(DEPTH), .SEC_W(SEC_W), .NS_W(NS_W), .PIN_IDX_W(PIN_IDX_W),
    .WORDS(WORDS), .WSEL_W(WSEL_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrPin(wrPin), .wordSel(wordSel),
    .timeSec(timeSec), .timeNs(timeNs), .readData(readData)
  );
endmodule

// File: tb/edge_stamp_fifo_bench.sv
module edge_stamp_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinIn = '0;
  logic [2*NP-1:0] edgeCfg = '0;
  logic [47:0]   timeSec = '0;
  logic [29:0]   timeNs = '0;
  logic          readNext = 1'b1;
  logic          readStrobe = 1'b0;
  logic          ptrReset = 1'b0;
  logic [15:0]   readData;
  logic [6:0]    fillLevel;
  logic          overrun;

  int total = 0;
  int failed = 0;
  bit done = 0;
  logic [95:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_stamp_fifo u_edge_stamp_fifo (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .edgeCfg(edgeCfg),
    .timeSec(timeSec), .timeNs(timeNs), .readNext(readNext),
    .readStrobe(readStrobe), .ptrReset(ptrReset), .readData(readData),
    .fillLevel(fillLevel), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] mkRec(input int pin, input logic [47:0] s, input logic [29:0] n);
    return {13'b0, 5'(pin), s, n};
  endfunction

  task automatic setCfg(input int pin, input logic [1:0] code);
    edgeCfg[2*pin +: 2] = code;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: pulse a pin high then low, pushing the expected record when asked
  task automatic firePin(input int pin, input bit expect_it);
    pinIn[pin] = 1'b1;
    waitCyc(6);
    pinIn[pin] = 1'b0;
    waitCyc(6);
    if (expect_it) expQ.push_back(mkRec(pin, timeSec, timeNs));
  endtask

  // Monitor: drain the design and compare each word with the scoreboard
  task automatic drain(input string req);
    while (fillLevel != 0) begin
      logic [95:0] exp;
      if (expQ.size() == 0) begin
        check(0, req, 96'(fillLevel), 96'd0);
        return;
      end
      exp = expQ.pop_front();
      for (int w = 0; w < 6; w++) begin
        check(readData == exp[16*w +: 16], req, 96'(readData), 96'(exp[16*w +: 16])); // R4 word order
        readNext = 1'b1;
        readStrobe = 1'b1;
        @(negedge clk);
        readStrobe = 1'b0;
      end
    end
    check(expQ.size() == 0, req, 96'(expQ.size()), 96'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failed++;
      total++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    // Reset state
    check(fillLevel == 0, "R3 reset fill", 96'(fillLevel), 96'd0);
    check(overrun == 0, "R7 reset overrun", 96'(overrun), 96'd0);
    check(readData == 0, "R4 empty readData", 96'(readData), 96'd0);

    // R10: latency through synchroniser
    setCfg(4, 2'b01);
    timeSec = 48'h1234_5678_9abc;
    timeNs  = 30'h2bad_cafe;
    pinIn[4] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(fillLevel == 0, "R10 not before 4th edge", 96'(fillLevel), 96'd0);
    @(negedge clk);
    check(fillLevel == 1, "R10 on 4th edge", 96'(fillLevel), 96'd1);
    expQ.push_back(mkRec(4, timeSec, timeNs));
    pinIn[4] = 1'b0;
    waitCyc(6);

    // R5: strobe with readNext low does nothing
    held = readData;
    readNext = 1'b0;
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
    @(negedge clk);
    check(readData == held, "R5 strobe ignored data", 96'(readData), 96'(held));
    check(fillLevel == 1, "R5 strobe ignored fill", 96'(fillLevel), 96'd1);
    readNext = 1'b1;
    drain("R2 R4 R5 first record");

    // R1: falling mode, disabled codes 00 and 11
    setCfg(7, 2'b10);
    setCfg(8, 2'b00);
    setCfg(9, 2'b11);
    timeNs = 30'd777;
    timeSec = 48'd5;
    pinIn[8] = 1'b1;
    pinIn[9] = 1'b1;
    pinIn[7] = 1'b1;
    waitCyc(8);
    check(fillLevel == 0, "R1 rise ignored in falling and off modes", 96'(fillLevel), 96'd0);
    pinIn[8] = 1'b0;
    pinIn[9] = 1'b0;
    pinIn[7] = 1'b0;
    waitCyc(8);
    check(fillLevel == 1, "R1 falling capture only", 96'(fillLevel), 96'd1);
    expQ.push_back(mkRec(7, timeSec, timeNs));
    drain("R1 R2 falling record");

    // R9: simultaneous pins in ascending order
    setCfg(2, 2'b01);
    setCfg(9, 2'b01);
    setCfg(15, 2'b01);
    timeNs = 30'h1555_0001;
    pinIn[15] = 1'b1;
    pinIn[9] = 1'b1;
    pinIn[2] = 1'b1;
    waitCyc(10);
    check(fillLevel == 3, "R9 three records", 96'(fillLevel), 96'd3);
    expQ.push_back(mkRec(2, timeSec, timeNs));
    expQ.push_back(mkRec(9, timeSec, timeNs));
    expQ.push_back(mkRec(15, timeSec, timeNs));
    pinIn[15] = 1'b0;
    pinIn[9] = 1'b0;
    pinIn[2] = 1'b0;
    waitCyc(6);
    drain("R9 ascending order");

    // R3, R7, R8: fill to 64, then overflow
    setCfg(0, 2'b01);
    for (int i = 0; i < 64; i++) begin
      timeNs = 30'(100 + i);
      timeSec = 48'(i * 3);
      firePin(0, 1'b1);
    end
    check(fillLevel == 64, "R3 full level", 96'(fillLevel), 96'd64);
    check(overrun == 0, "R7 no overrun yet", 96'(overrun), 96'd0);
    timeNs = 30'd999;
    firePin(0, 1'b0);
    check(fillLevel == 64, "R8 dropped when full", 96'(fillLevel), 96'd64);
    check(overrun == 1, "R7 overrun raised", 96'(overrun), 96'd1);
    drain("R8 oldest records kept");
    check(overrun == 1, "R7 overrun sticky", 96'(overrun), 96'd1);

    // R6: pointer reset
    timeNs = 30'd42;
    firePin(0, 1'b0);
    firePin(0, 1'b0);
    check(fillLevel == 2, "R6 before clear", 96'(fillLevel), 96'd2);
    ptrReset = 1'b1;
    @(negedge clk);
    ptrReset = 1'b0;
    check(fillLevel == 0, "R6 cleared fill", 96'(fillLevel), 96'd0);
    check(overrun == 0, "R6 cleared overrun", 96'(overrun), 96'd0);
    check(readData == 0, "R6 R4 empty data", 96'(readData), 96'd0);
    timeNs = 30'd43;
    firePin(0, 1'b1);
    drain("R6 works after clear");

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule